// File: doc/BRIEF.md
# In-Switch Collective Reduction Engine

This block sits inside a switch and performs symmetric collectives (AllReduce style) on tensor fragments pushed by a group of accelerators. Every ingress word carries a compute header with a group number, the contributing member, an operation, an element type and a fragment offset. The reduction logic looks only at this header and the 32-bit payload word. A configuration port registers a group by writing a non-zero member mask. The same port loads each member's real base address for that group.

Each registered group owns one accumulation slot. The first accepted contribution fixes the slot's operation, type and offset. Later contributions are combined into the slot and mark the member in an arrival bitmap. When the bitmap equals the group's member mask, a drain sequencer multicasts the result. It sends one copy per member, one per cycle, in ascending member order. Each copy is addressed to that member's base plus the fragment offset. After the last copy the slot is cleared for the next round. Packets that break a rule are dropped and set a sticky error flag.

Top module: `coll_reduce_engine`

## Requirements
- R1: After reset `out_valid` and `err_flag` are 0 and no group is registered (every member mask is zero).
- R2: A group is registered by a configuration write with `cfg_sel`=0 and a non-zero `cfg_mask`. A zero mask unregisters it. A packet for a group whose mask is zero is dropped and sets `err_flag` on the next cycle.
- R3: `in_op` encodes 0 = minimum, 1 = sum, 2 = maximum. Code 3 is dropped and sets `err_flag`.
- R4: `in_type` encodes 0 = INT32, 1 = FP8 (four 8-bit lanes, lane 0 at bits 7:0), 2 = FP16 (two 16-bit lanes), 3 = FP32, 4 = BF16 (two 16-bit lanes). Codes 5 to 7 are dropped and set `err_flag`.
- R5: Sum is supported only for INT32 and wraps modulo 2^32. A sum request with any other type is dropped and sets `err_flag`.
- R6: INT32 minimum and maximum compare the values as signed two's complement numbers.
- R7: Floating-point minimum and maximum work per lane, using a sign-magnitude order. A lane with its sign bit set is below any lane with its sign bit clear, including -0 below +0. Among negative lanes, the larger magnitude is smaller. Among positive lanes, the larger magnitude is larger.
- R8: A result is released only after every member in the group's mask has contributed. A contribution from a member outside the mask is dropped and sets `err_flag`.
- R9: A second contribution from the same member before the result is released is dropped, sets `err_flag` and leaves the accumulated value unchanged.
- R10: The first contribution of a round fixes the operation, type and offset. A later contribution that differs in any of the three is dropped and sets `err_flag`.
- R11: Copies leave one per consecutive cycle in ascending member index, with `out_group` naming the group. The first copy is valid in the second cycle after the clock edge that accepted the completing contribution. A group that completes while another is draining is sent afterwards.
- R12: Each copy's `out_addr` equals that member's configured base address for the group plus the fragment offset, modulo 2^AW.
- R13: After the last copy the slot's bitmap and accumulator are cleared, so the next round starts from its own first contribution.
- R14: `err_flag` stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_valid | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 = write group mask, 1 = write member base address |
| cfg_group | input | GW | Group being configured |
| cfg_member | input | MW | Member whose base address is written |
| cfg_mask | input | MEMBERS | Member mask for the group |
| cfg_base | input | AW | Member's real base address |
| in_valid | input | 1 | Ingress contribution valid |
| in_group | input | GW | Header: group number |
| in_member | input | MW | Header: contributing member |
| in_op | input | 2 | Header: operation code |
| in_type | input | 3 | Header: element type code |
| in_offset | input | OW | Header: fragment offset |
| in_data | input | 32 | Payload word |
| out_valid | output | 1 | Multicast copy valid |
| out_group | output | GW | Group of the copy |
| out_member | output | MW | Destination member |
| out_addr | output | AW | Member's real destination address |
| out_data | output | 32 | Reduced result |
| err_flag | output | 1 | Sticky drop indicator |

## Verification
The bench targets the float compare on signed-zero and all-negative lanes, and on narrow lanes packed in one word. A design that used integer compare or full-word compare would return -0 or the wrong lane there. INT32 sum is driven across the wrap point, and INT32 max is run on all-negative inputs that a sign-magnitude compare would order backwards. Duplicate, non-member and header-mismatch contributions are injected into an open round. A design that accepted them would release early, corrupt the sum or move the offset. A second group is completed while the first is still draining, which catches a sequencer that loses or interleaves copies.

// File: rtl/coll_reduce_engine.sv
module coll_reduce_engine #(
  parameter int MEMBERS = 4,
  parameter int GROUPS  = 4,
  parameter int AW      = 32,
  parameter int OW      = 16,
  localparam int MW = $clog2(MEMBERS),
  localparam int GW = $clog2(GROUPS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_valid,
  input  logic               cfg_sel,
  input  logic [GW-1:0]      cfg_group,
  input  logic [MW-1:0]      cfg_member,
  input  logic [MEMBERS-1:0] cfg_mask,
  input  logic [AW-1:0]      cfg_base,
  input  logic               in_valid,
  input  logic [GW-1:0]      in_group,
  input  logic [MW-1:0]      in_member,
  input  logic [1:0]         in_op,
  input  logic [2:0]         in_type,
  input  logic [OW-1:0]      in_offset,
  input  logic [31:0]        in_data,
  output logic               out_valid,
  output logic [GW-1:0]      out_group,
  output logic [MW-1:0]      out_member,
  output logic [AW-1:0]      out_addr,
  output logic [31:0]        out_data,
  output logic               err_flag
);
  localparam logic [1:0] OP_MIN = 2'd0, OP_SUM = 2'd1, OP_MAX = 2'd2;
  localparam logic [2:0] T_INT = 3'd0, T_FP8 = 3'd1, T_FP32 = 3'd3, T_LAST = 3'd4;

  logic [MEMBERS-1:0] grp_mask [GROUPS];
  logic [AW-1:0]      base     [GROUPS][MEMBERS];
  logic [31:0]        acc      [GROUPS];
  logic [MEMBERS-1:0] arrived  [GROUPS];
  logic [1:0]         s_op     [GROUPS];
  logic [2:0]         s_type   [GROUPS];
  logic [OW-1:0]      s_off    [GROUPS];

  logic               busy;
  logic [GW-1:0]      cur_g;
  logic [MEMBERS-1:0] rem;

  function automatic logic [32:0] sm_key(input logic [31:0] x, input int w);
    logic [32:0] lim, mag;
    lim = (33'd1 << (w - 1)) - 33'd1;
    mag = {1'b0, x} & lim;
    return x[w-1] ? lim - mag : lim + 33'd1 + mag;
  endfunction

  function automatic logic [31:0] combine(input logic [1:0] op, input logic [2:0] ty,
                                          input logic [31:0] a, input logic [31:0] b);
    logic [31:0] r, lm, pick;
    logic        lt;
    int          w, sh;
    if (op == OP_SUM) return a + b;
    if (ty == T_INT) begin
      lt = $signed(a) < $signed(b);
      return (lt ^ (op == OP_MAX)) ? a : b;
    end
    w  = (ty == T_FP8) ? 8 : (ty == T_FP32) ? 32 : 16;
    lm = 32'((33'd1 << w) - 33'd1);
    r  = '0;
    for (int l = 0; l < 4; l++) begin
      if (l * w < 32) begin
        sh   = l * w;
        lt   = sm_key(a >> sh, w) < sm_key(b >> sh, w);
        pick = (lt ^ (op == OP_MAX)) ? a : b;
        r    = r | (pick & (lm << sh));
      end
    end
    return r;
  endfunction

  wire hdr_ok = (in_op != 2'd3) && (in_type <= T_LAST) && !(in_op == OP_SUM && in_type != T_INT);
  wire first  = (arrived[in_group] == '0);
  wire same   = first || (s_op[in_group] == in_op && s_type[in_group] == in_type
                          && s_off[in_group] == in_offset);
  wire accept = in_valid && (|grp_mask[in_group]) && grp_mask[in_group][in_member]
                && hdr_ok && !arrived[in_group][in_member] && same;

  logic [GROUPS-1:0] ready;
  logic [GW-1:0]     pick_g;
  logic [MW-1:0]     nxt;
  logic [MEMBERS-1:0] nxt_bit;

  always_comb begin
    pick_g = '0;
    for (int g = GROUPS - 1; g >= 0; g--) begin
      ready[g] = (|grp_mask[g]) && (arrived[g] == grp_mask[g]);
      if (ready[g]) pick_g = GW'(g);
    end
    nxt = '0;
    for (int m = MEMBERS - 1; m >= 0; m--)
      if (rem[m]) nxt = MW'(m);
    nxt_bit = '0;
    nxt_bit[nxt] = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy <= 1'b0; cur_g <= '0; rem <= '0; err_flag <= 1'b0;
      out_valid <= 1'b0; out_group <= '0; out_member <= '0; out_addr <= '0; out_data <= '0;
      for (int g = 0; g < GROUPS; g++) begin
        grp_mask[g] <= '0; acc[g] <= '0; arrived[g] <= '0;
        s_op[g] <= '0; s_type[g] <= '0; s_off[g] <= '0;
        for (int m = 0; m < MEMBERS; m++) base[g][m] <= '0;
      end
    end else begin
      if (cfg_valid) begin
        if (cfg_sel) base[cfg_group][cfg_member] <= cfg_base;
        else         grp_mask[cfg_group] <= cfg_mask;
      end

      if (in_valid && !accept) err_flag <= 1'b1;
      if (accept) begin
        arrived[in_group][in_member] <= 1'b1;
        if (first) begin
          acc[in_group]    <= in_data;
          s_op[in_group]   <= in_op;
          s_type[in_group] <= in_type;
          s_off[in_group]  <= in_offset;
        end else begin
          acc[in_group] <= combine(s_op[in_group], s_type[in_group], acc[in_group], in_data);
        end
      end

      out_valid <= 1'b0;
      if (!busy) begin
        if (|ready) begin
          busy  <= 1'b1;
          cur_g <= pick_g;
          rem   <= grp_mask[pick_g];
        end
      end else begin
        out_valid  <= 1'b1;
        out_group  <= cur_g;
        out_member <= nxt;
        out_addr   <= base[cur_g][nxt] + AW'(s_off[cur_g]);
        out_data   <= acc[cur_g];
        rem        <= rem & ~nxt_bit;
        if ((rem & ~nxt_bit) == '0) begin
          busy         <= 1'b0;
          arrived[cur_g] <= '0;
          acc[cur_g]     <= '0;
        end
      end
    end
  end
endmodule

// File: rtl/coll_reduce_chk.sv
module coll_reduce_chk #(
  parameter int MEMBERS = 4,
  parameter int GROUPS  = 4,
  localparam int MW = $clog2(MEMBERS),
  localparam int GW = $clog2(GROUPS)
) (
  input logic               clk,
  input logic               rst_n,
  input logic               in_valid,
  input logic [GW-1:0]      in_group,
  input logic [1:0]         in_op,
  input logic [MEMBERS-1:0] mask [GROUPS],
  input logic               out_valid,
  input logic [GW-1:0]      out_group,
  input logic [MW-1:0]      out_member,
  input logic               err_flag
);
  // R1
  reset_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !out_valid && !err_flag);

  // R2
  unreg_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && (mask[in_group] == '0) |=> err_flag);

  // R3
  bad_op_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_op == 2'd3 |=> err_flag);

  // R8
  member_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> mask[out_group][out_member]);

  // R11
  ascending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && $past(out_valid) && out_group == $past(out_group)
      |-> out_member > $past(out_member));

  // R14
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err_flag |=> err_flag);
endmodule

bind coll_reduce_engine coll_reduce_chk #(.MEMBERS(MEMBERS), .GROUPS(GROUPS)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_group(in_group), .in_op(in_op),
  .mask(grp_mask), .out_valid(out_valid), .out_group(out_group),
  .out_member(out_member), .err_flag(err_flag));

// File: tb/tb_coll_reduce_engine.sv
`timescale 1ns/1ps
module tb_coll_reduce_engine;
  localparam int M = 4, G = 4, AW = 32, OW = 16, MW = 2, GW = 2;

  typedef struct packed {
    logic [1:0]  op;
    logic [2:0]  ty;
    logic [31:0] a, b, c, d, exp;
  } vec_t;

  localparam vec_t VECS [10] = '{
    '{2'd1, 3'd0, 32'h00000001, 32'h00000002, 32'h00000003, 32'h00000004, 32'h0000000A},
    '{2'd1, 3'd0, 32'hFFFFFFFF, 32'h00000002, 32'h00000000, 32'h00000000, 32'h00000001},
    '{2'd0, 3'd0, 32'h00000005, 32'hFFFFFFFE, 32'h00000007, 32'h00000000, 32'hFFFFFFFE},
    '{2'd2, 3'd0, 32'h80000000, 32'h7FFFFFFF, 32'h00000000, 32'hFFFFFFFF, 32'h7FFFFFFF},
    '{2'd0, 3'd3, 32'h3F800000, 32'hBF800000, 32'hC0000000, 32'h40000000, 32'hC0000000},
    '{2'd2, 3'd3, 32'h80000000, 32'h00000000, 32'h80000000, 32'h80000000, 32'h00000000},
    '{2'd2, 3'd2, 32'h3C00BC00, 32'hC0004000, 32'h00008000, 32'h3E003800, 32'h3E004000},
    '{2'd0, 3'd1, 32'h01817F00, 32'h0280FF10, 32'h00850090, 32'h0301808F, 32'h0085FF90},
    '{2'd0, 3'd4, 32'h3F800000, 32'hBF808000, 32'h40000001, 32'h00000000, 32'hBF808000},
    '{2'd2, 3'd0, 32'hFFFFFFFF, 32'hFFFFFFFE, 32'h80000001, 32'h80000000, 32'hFFFFFFFF}
  };

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rst_n = 1'b0;
  logic cfg_valid = 0, cfg_sel = 0;
  logic [GW-1:0] cfg_group = '0;
  logic [MW-1:0] cfg_member = '0;
  logic [M-1:0] cfg_mask = '0;
  logic [AW-1:0] cfg_base = '0;
  logic in_valid = 0;
  logic [GW-1:0] in_group = '0;
  logic [MW-1:0] in_member = '0;
  logic [1:0] in_op = '0;
  logic [2:0] in_type = '0;
  logic [OW-1:0] in_offset = '0;
  logic [31:0] in_data = '0;
  logic out_valid, err_flag;
  logic [GW-1:0] out_group;
  logic [MW-1:0] out_member;
  logic [AW-1:0] out_addr;
  logic [31:0] out_data;

  coll_reduce_engine #(.MEMBERS(M), .GROUPS(G), .AW(AW), .OW(OW)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid), .cfg_sel(cfg_sel),
    .cfg_group(cfg_group), .cfg_member(cfg_member), .cfg_mask(cfg_mask), .cfg_base(cfg_base),
    .in_valid(in_valid), .in_group(in_group), .in_member(in_member), .in_op(in_op),
    .in_type(in_type), .in_offset(in_offset), .in_data(in_data),
    .out_valid(out_valid), .out_group(out_group), .out_member(out_member),
    .out_addr(out_addr), .out_data(out_data), .err_flag(err_flag));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  logic [31:0] c_data [256];
  logic [31:0] c_addr [256];
  int c_mem [256], c_grp [256], c_cyc [256];
  int ncap = 0;
  always @(negedge clk) begin
    if (rst_n && out_valid && ncap < 256) begin
      c_data[ncap] = out_data; c_addr[ncap] = out_addr;
      c_mem[ncap] = int'(out_member); c_grp[ncap] = int'(out_group); c_cyc[ncap] = cyc;
      ncap++;
    end
  end

  int checks = 0, fails = 0, sent_cyc = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input bit sel, input int g, input int m, input int mask,
                           input logic [AW-1:0] b);
    @(negedge clk);
    cfg_valid = 1; cfg_sel = sel; cfg_group = GW'(g); cfg_member = MW'(m);
    cfg_mask = M'(mask); cfg_base = b;
    @(negedge clk);
    cfg_valid = 0;
  endtask

  task automatic send(input int g, input int m, input logic [1:0] op, input logic [2:0] ty,
                      input int off, input logic [31:0] d);
    @(negedge clk);
    in_valid = 1; in_group = GW'(g); in_member = MW'(m); in_op = op; in_type = ty;
    in_offset = OW'(off); in_data = d;
    @(negedge clk);
    in_valid = 0;
    sent_cyc = cyc;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; in_valid = 0; cfg_valid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic setup();
    cfg_write(0, 1, 0, 4'b1111, '0);
    cfg_write(0, 0, 0, 4'b0101, '0);
    for (int m = 0; m < M; m++) begin
      cfg_write(1, 1, m, 0, 32'h1000_0000 + 32'(m) * 32'h100);
      cfg_write(1, 0, m, 0, 32'h2000_0000 + 32'(m) * 32'h40);
    end
  endtask

  function automatic string req_of(input logic [1:0] op, input logic [2:0] ty);
    if (op == 2'd1) return "R5";
    if (ty == 3'd0) return "R6";
    return "R7";
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d [4];
    int st, first_sent, m;

    do_reset();
    check(out_valid == 0, "R1", "out_valid after reset", out_valid, 0);
    check(err_flag == 0, "R1", "err_flag after reset", err_flag, 0);
    // R2: nothing registered yet
    send(1, 0, 2'd1, 3'd0, 0, 32'd1);
    check(err_flag == 1, "R2", "unregistered group err", err_flag, 1);

    do_reset();
    setup();
    // table walk; reusing group 1 every round also exercises R13
    for (int v = 0; v < 10; v++) begin
      st = ncap;
      d[0] = VECS[v].a; d[1] = VECS[v].b; d[2] = VECS[v].c; d[3] = VECS[v].d;
      for (int k = 0; k < 4; k++) begin
        m = (v % 2 == 1) ? 3 - k : k;
        send(1, m, VECS[v].op, VECS[v].ty, v * 4, d[m]);
      end
      first_sent = sent_cyc;
      repeat (8) @(negedge clk);
      check(ncap - st == 4, "R8", "copies per round", ncap - st, 4);
      check(c_cyc[st] == first_sent + 2, "R11", "first copy cycle", c_cyc[st], first_sent + 2);
      for (int k = 0; k < 4; k++) begin
        check(c_data[st+k] == VECS[v].exp, req_of(VECS[v].op, VECS[v].ty), "result",
              c_data[st+k], VECS[v].exp);
        check(c_mem[st+k] == k && c_cyc[st+k] == c_cyc[st] + k, "R11", "member order",
              c_mem[st+k], k);
        check(c_addr[st+k] == 32'h1000_0000 + 32'(k) * 32'h100 + 32'(v * 4), "R12", "address",
              c_addr[st+k], 32'h1000_0000 + 32'(k) * 32'h100 + 32'(v * 4));
      end
    end
    check(err_flag == 0, "R13", "clean rounds raise no error", err_flag, 0);

    do_reset(); setup();
    send(1, 0, 2'd3, 3'd0, 0, 32'd5);
    check(err_flag == 1, "R3", "op code 3 dropped", err_flag, 1);

    do_reset(); setup();
    send(1, 0, 2'd0, 3'd5, 0, 32'd5);
    check(err_flag == 1, "R4", "type code 5 dropped", err_flag, 1);

    do_reset(); setup();
    send(1, 0, 2'd1, 3'd3, 0, 32'd5);
    check(err_flag == 1, "R5", "float sum dropped", err_flag, 1);

    do_reset(); setup();
    st = ncap;
    send(0, 1, 2'd1, 3'd0, 0, 32'd100);
    check(err_flag == 1, "R8", "non-member dropped", err_flag, 1);
    send(0, 0, 2'd1, 3'd0, 0, 32'd5);
    repeat (4) @(negedge clk);
    check(ncap == st, "R8", "no release on partial set", ncap - st, 0);
    send(0, 2, 2'd1, 3'd0, 0, 32'd7);
    repeat (6) @(negedge clk);
    check(ncap - st == 2, "R8", "two copies for two members", ncap - st, 2);
    check(c_mem[st] == 0 && c_mem[st+1] == 2, "R11", "skips non-member", c_mem[st+1], 2);
    check(c_cyc[st+1] == c_cyc[st] + 1, "R11", "consecutive", c_cyc[st+1], c_cyc[st] + 1);
    check(c_data[st] == 32'd12, "R8", "non-member not summed", c_data[st], 12);
    check(c_addr[st+1] == 32'h2000_0080, "R12", "member 2 address", c_addr[st+1], 32'h2000_0080);
    check(err_flag == 1, "R14", "err stays set", err_flag, 1);

    do_reset(); setup();
    st = ncap;
    send(0, 0, 2'd1, 3'd0, 0, 32'd5);
    send(0, 0, 2'd1, 3'd0, 0, 32'd100);
    check(err_flag == 1, "R9", "duplicate flagged", err_flag, 1);
    send(0, 2, 2'd1, 3'd0, 0, 32'd7);
    repeat (6) @(negedge clk);
    check(ncap - st == 2 && c_data[st] == 32'd12, "R9", "duplicate ignored", c_data[st], 12);

    do_reset(); setup();
    st = ncap;
    send(0, 0, 2'd1, 3'd0, 8, 32'd1);
    send(0, 2, 2'd1, 3'd0, 12, 32'd2);
    check(err_flag == 1, "R10", "offset mismatch flagged", err_flag, 1);
    send(0, 2, 2'd0, 3'd0, 8, 32'd2);
    repeat (4) @(negedge clk);
    check(ncap == st, "R10", "mismatches not counted", ncap - st, 0);
    send(0, 2, 2'd1, 3'd0, 8, 32'd2);
    repeat (6) @(negedge clk);
    check(ncap - st == 2 && c_data[st] == 32'd3, "R10", "matching sum", c_data[st], 3);
    check(c_addr[st] == 32'h2000_0008, "R12", "offset applied", c_addr[st], 32'h2000_0008);
    st = ncap;
    send(0, 2, 2'd1, 3'd0, 4, 32'd20);
    send(0, 0, 2'd1, 3'd0, 4, 32'd10);
    repeat (6) @(negedge clk);
    check(ncap - st == 2 && c_data[st] == 32'd30, "R13", "slot cleared for reuse", c_data[st], 30);
    check(c_addr[st] == 32'h2000_0004, "R13", "new offset taken", c_addr[st], 32'h2000_0004);

    do_reset(); setup();
    st = ncap;
    for (int k = 0; k < 3; k++) send(1, k, 2'd1, 3'd0, 0, 32'd1);
    send(0, 0, 2'd1, 3'd0, 0, 32'd2);
    @(negedge clk);
    in_valid = 1; in_group = 2'd1; in_member = 2'd3; in_op = 2'd1; in_type = 3'd0;
    in_offset = '0; in_data = 32'd1;
    @(negedge clk);
    in_group = 2'd0; in_member = 2'd2; in_data = 32'd3;
    @(negedge clk);
    in_valid = 0;
    repeat (12) @(negedge clk);
    check(ncap - st == 6, "R11", "queued group not lost", ncap - st, 6);
    check(c_grp[st+3] == 1 && c_grp[st+4] == 0, "R11", "queued group follows", c_grp[st+4], 0);
    check(c_data[st] == 32'd4 && c_data[st+4] == 32'd5, "R11", "both results",
          c_data[st+4], 5);
    check(err_flag == 0, "R11", "no error on overlap", err_flag, 0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule